// File: doc/BRIEF.md
# Compressed Chunk Tokenizer

This block sits between a byte FIFO and a pixel reconstruction stage in an image decompression pipeline. The FIFO side delivers fixed-width words of five bytes. The output side expects one descriptor per compressed chunk. A chunk is one to five bytes long, and chunks carry no alignment to word boundaries. The block holds unconsumed bytes in a residual window and looks at the first byte of that window to find the chunk kind and length. When enough bytes are present, it offers the whole chunk as a single descriptor. Each descriptor carries the chunk kind, the raw chunk bytes and the number of pixels the chunk stands for.

Both edges use valid/ready handshakes, so downstream backpressure stalls the tokenizer, and the tokenizer in turn stalls the FIFO. A flag on the last input word marks the frame end. The final complete chunk of the frame is flagged on the output. After that, the block takes no input until the final descriptor has left. It then accepts the next frame.

Top module: `chunk_tokenizer`

## Requirements
- R1: The first byte of a chunk selects its kind and total length. The full-byte tags are checked first: 0xFF gives RGBA (kind 5, 5 bytes) and 0xFE gives RGB (kind 4, 4 bytes). For every other byte, bits [7:6] decide: 00 gives INDEX (kind 0, 1 byte), 01 gives DIFF (kind 1, 1 byte), 10 gives LUMA (kind 2, 2 bytes) and 11 gives RUN (kind 3, 1 byte).
- R2: `desc_bytes_o` carries the chunk bytes in stream order, with the first byte at [39:32], the next at [31:24], and so on. Byte positions beyond the chunk length read zero.
- R3: For a RUN chunk, `desc_run_o` is the tag byte's bits [5:0] plus one, which gives 1 to 62. For every other kind it is 1.
- R4: In an input word, byte 0 sits at `word_i[39:32]`. A word without `word_last_i` carries five bytes. A word with `word_last_i` carries `word_bytes_i` bytes (1 to 5) in its top positions, and the bytes below them are ignored.
- R5: Chunks that straddle input words are reassembled correctly. Exactly one descriptor is produced per chunk, in stream order.
- R6: A descriptor transfers on a cycle with `desc_valid_o` and `desc_ready_i` both high. While it is stalled, the valid signal and all descriptor fields hold steady.
- R7: When a frame ends on a chunk boundary, its final chunk has `desc_last_o` high and every other chunk has it low.
- R8: Once a word with `word_last_i` is accepted, `word_ready_o` stays low until the frame's final descriptor has transferred or its tail has been dropped. After that, the next frame is accepted.
- R9: If a frame ends partway through a chunk, the partial tail is dropped. It produces no descriptor, no descriptor of that frame is flagged last, and the next frame decodes normally.
- R10: During reset, `desc_valid_o` is low and `word_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 40 | Five packed bytes, byte 0 in the top position |
| word_bytes_i | input | 4 | Valid byte count of the last word of a frame |
| word_valid_i | input | 1 | Input word valid |
| word_last_i | input | 1 | Input word is the last of its frame |
| word_ready_o | output | 1 | Input word accepted on this cycle if valid |
| desc_valid_o | output | 1 | Descriptor valid |
| desc_ready_i | input | 1 | Downstream accepts descriptor |
| desc_kind_o | output | 3 | Chunk kind code |
| desc_bytes_o | output | 40 | Raw chunk bytes, first byte on top, rest zero |
| desc_run_o | output | 6 | Pixels represented by the chunk |
| desc_last_o | output | 1 | Final chunk of the frame |

## Verification
A wrong byte count in the window shows up directly at the ports. All later chunks are then cut at the wrong places, so the very next descriptor carries the wrong kind or bytes, or the stream stalls with `word_ready_o` low. A residual byte that is lost or duplicated across a word boundary likewise corrupts the first straddling chunk, on the cycle it is offered. A stuck frame-end flag shows up as a missing or misplaced `desc_last_o`. It also shows up as `word_ready_o` failing to close after the last word, or failing to reopen after the final descriptor. The bench applies chunk mixes under free-running, random and mostly-stalled output readiness, and compares every transfer against a byte-queue model.

// File: rtl/tok_pkg.sv
package tok_pkg;
  typedef enum logic [2:0] {
    K_INDEX = 3'd0,
    K_DIFF  = 3'd1,
    K_LUMA  = 3'd2,
    K_RUN   = 3'd3,
    K_RGB   = 3'd4,
    K_RGBA  = 3'd5
  } chunk_kind_e;

  localparam logic [7:0] TAG_RGB  = 8'hFE;
  localparam logic [7:0] TAG_RGBA = 8'hFF;
endpackage

// File: rtl/tok_classify.sv
module tok_classify import tok_pkg::*; #(
  parameter int unsigned LEN_W = 4
) (
  input  logic [7:0]       head_i,
  output chunk_kind_e      kind_o,
  output logic [LEN_W-1:0] len_o,
  output logic [5:0]       run_o
);
  always_comb begin
    run_o = 6'd1;
    if (head_i == TAG_RGBA) begin
      kind_o = K_RGBA;
      len_o  = LEN_W'(5);
    end else if (head_i == TAG_RGB) begin
      kind_o = K_RGB;
      len_o  = LEN_W'(4);
    end else begin
      unique case (head_i[7:6])
        2'b00: begin kind_o = K_INDEX; len_o = LEN_W'(1); end
        2'b01: begin kind_o = K_DIFF;  len_o = LEN_W'(1); end
        2'b10: begin kind_o = K_LUMA;  len_o = LEN_W'(2); end
        default: begin
          kind_o = K_RUN;
          len_o  = LEN_W'(1);
          run_o  = head_i[5:0] + 6'd1;
        end
      endcase
    end
  end
endmodule

// File: rtl/tok_window.sv
module tok_window #(
  parameter int unsigned WORD_BYTES = 5,
  parameter int unsigned CNT_W      = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    pop_i,
  input  logic [CNT_W-1:0]        pop_len_i,
  input  logic                    push_i,
  input  logic [WORD_BYTES*8-1:0] push_data_i,
  input  logic [CNT_W-1:0]        push_cnt_i,
  output logic [WORD_BYTES*8-1:0] head_o,
  output logic [CNT_W-1:0]        cnt_o
);
  localparam int unsigned WIN = 2 * WORD_BYTES;
  localparam int unsigned WW  = WIN * 8;
  localparam int unsigned HW  = WORD_BYTES * 8;

  logic [WW-1:0]    win_q, win_d, shifted, placed;
  logic [CNT_W-1:0] cnt_q, cnt_d, rem;
  logic [HW-1:0]    push_masked;

  // drop bytes beyond the stated count of a short word
  for (genvar gb = 0; gb < WORD_BYTES; gb++) begin : g_keep
    assign push_masked[HW-1-8*gb -: 8] =
      (CNT_W'(gb) < push_cnt_i) ? push_data_i[HW-1-8*gb -: 8] : 8'h00;
  end

  always_comb begin
    rem     = pop_i ? cnt_q - pop_len_i : cnt_q;
    shifted = pop_i ? win_q << {pop_len_i, 3'b000} : win_q;
    placed  = {push_masked, {HW{1'b0}}} >> {rem, 3'b000};
    win_d   = shifted | (push_i ? placed : '0);
    cnt_d   = rem + (push_i ? push_cnt_i : '0);
    if (flush_i) begin
      win_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_o = win_q[WW-1 -: HW];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/chunk_tokenizer.sv
module chunk_tokenizer import tok_pkg::*; #(
  parameter  int unsigned WORD_BYTES = 5,
  localparam int unsigned CNT_W      = $clog2(2 * WORD_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [WORD_BYTES*8-1:0] word_i,
  input  logic [CNT_W-1:0]        word_bytes_i,
  input  logic                    word_valid_i,
  input  logic                    word_last_i,
  output logic                    word_ready_o,
  output logic                    desc_valid_o,
  input  logic                    desc_ready_i,
  output logic [2:0]              desc_kind_o,
  output logic [WORD_BYTES*8-1:0] desc_bytes_o,
  output logic [5:0]              desc_run_o,
  output logic                    desc_last_o
);
  localparam int unsigned WIN = 2 * WORD_BYTES;
  localparam int unsigned HW  = WORD_BYTES * 8;

  logic [HW-1:0]    head;
  logic [CNT_W-1:0] cnt, len, push_cnt;
  chunk_kind_e      kind;
  logic             last_q, whole, pop, push, flush, final_chunk;

  tok_window #(.WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .pop_i       (pop),
    .pop_len_i   (len),
    .push_i      (push),
    .push_data_i (word_i),
    .push_cnt_i  (push_cnt),
    .head_o      (head),
    .cnt_o       (cnt)
  );

  tok_classify #(.LEN_W(CNT_W)) u_cls (
    .head_i (head[HW-1 -: 8]),
    .kind_o (kind),
    .len_o  (len),
    .run_o  (desc_run_o)
  );

  assign whole       = (cnt != '0) && (cnt >= len);
  assign final_chunk = last_q && (cnt == len);
  assign flush       = last_q && !whole;  // truncated or empty tail
  assign pop         = whole && desc_ready_i;
  assign word_ready_o = !last_q && (cnt <= CNT_W'(WIN - WORD_BYTES));
  assign push        = word_valid_i && word_ready_o;
  assign push_cnt    = word_last_i ? word_bytes_i : CNT_W'(WORD_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      last_q <= 1'b0;
    else if (flush || (pop && final_chunk)) last_q <= 1'b0;
    else if (push && word_last_i)     last_q <= 1'b1;
  end

  for (genvar gb = 0; gb < WORD_BYTES; gb++) begin : g_out
    assign desc_bytes_o[HW-1-8*gb -: 8] =
      (CNT_W'(gb) < len) ? head[HW-1-8*gb -: 8] : 8'h00;
  end

  assign desc_valid_o = whole;
  assign desc_kind_o  = kind;
  assign desc_last_o  = final_chunk;
endmodule

// File: rtl/tok_checker.sv
module tok_checker import tok_pkg::*; #(
  parameter int unsigned WORD_BYTES = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    word_valid_i,
  input logic                    word_last_i,
  input logic                    word_ready_o,
  input logic                    desc_valid_o,
  input logic                    desc_ready_i,
  input logic [2:0]              desc_kind_o,
  input logic [WORD_BYTES*8-1:0] desc_bytes_o,
  input logic [5:0]              desc_run_o,
  input logic                    desc_last_o
);
  localparam int unsigned HW = WORD_BYTES * 8;

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_ready_i) |=> (desc_valid_o && $stable(desc_bytes_o)
      && $stable(desc_kind_o) && $stable(desc_run_o) && $stable(desc_last_o)));

  a_r8_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o && word_last_i) |=> !word_ready_o);

  a_r8_reopen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_ready_i && desc_last_o) |=> word_ready_o);

  a_r3_run_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_kind_o == K_RUN) |-> (desc_run_o >= 6'd1 && desc_run_o <= 6'd62));

  a_r3_single_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_kind_o != K_RUN) |-> (desc_run_o == 6'd1));

  a_r1_rgba_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_bytes_o[HW-1 -: 8] == TAG_RGBA) |-> (desc_kind_o == K_RGBA));

  a_r2_short_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && (desc_kind_o == K_INDEX || desc_kind_o == K_DIFF || desc_kind_o == K_RUN))
      |-> (desc_bytes_o[HW-9:0] == '0));
endmodule

bind chunk_tokenizer tok_checker #(.WORD_BYTES(WORD_BYTES)) u_tok_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .word_last_i  (word_last_i),
  .word_ready_o (word_ready_o),
  .desc_valid_o (desc_valid_o),
  .desc_ready_i (desc_ready_i),
  .desc_kind_o  (desc_kind_o),
  .desc_bytes_o (desc_bytes_o),
  .desc_run_o   (desc_run_o),
  .desc_last_o  (desc_last_o)
);

// File: tb/chunk_tokenizer_test.sv
module chunk_tokenizer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:0] word_i = '0;
  logic [3:0]  word_bytes_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_last_i = 1'b0;
  logic        word_ready_o;
  logic        desc_valid_o;
  logic        desc_ready_i = 1'b0;
  logic [2:0]  desc_kind_o;
  logic [39:0] desc_bytes_o;
  logic [5:0]  desc_run_o;
  logic        desc_last_o;

  chunk_tokenizer uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int vectors = 0;
  int fails = 0;
  int rdy_mode = 0;
  int gap_pct = 0;
  logic [7:0]  frm[$];
  logic [39:0] exp_bytes[$];
  int          exp_kind[$];
  int          exp_run[$];
  bit          exp_last[$];

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_rand();
    int k = $urandom_range(5, 0);
    case (k)
      0: frm.push_back({2'b00, 6'($urandom)});
      1: frm.push_back({2'b01, 6'($urandom)});
      2: begin frm.push_back({2'b10, 6'($urandom)}); frm.push_back(8'($urandom)); end
      3: frm.push_back({2'b11, 6'($urandom_range(61, 0))});
      4: begin frm.push_back(8'hFE); for (int i = 0; i < 3; i++) frm.push_back(8'($urandom)); end
      default: begin frm.push_back(8'hFF); for (int i = 0; i < 4; i++) frm.push_back(8'($urandom)); end
    endcase
  endtask

  // byte-queue model of the chunk grammar
  task automatic expect_frame();
    int pos = 0;
    int n = frm.size();
    while (pos < n) begin
      logic [7:0]  b = frm[pos];
      logic [39:0] bytes = '0;
      int kind, len, run;
      run = 1;
      if (b == 8'hFF) begin kind = 5; len = 5; end
      else if (b == 8'hFE) begin kind = 4; len = 4; end
      else begin
        kind = int'(b[7:6]);
        len = (kind == 2) ? 2 : 1;
        if (kind == 3) run = int'(b[5:0]) + 1;
      end
      if (pos + len > n) break;
      for (int i = 0; i < len; i++) bytes[39-8*i -: 8] = frm[pos+i];
      exp_bytes.push_back(bytes);
      exp_kind.push_back(kind);
      exp_run.push_back(run);
      exp_last.push_back(pos + len == n);
      pos += len;
    end
  endtask

  task automatic send_frame();
    int idx = 0;
    int n = frm.size();
    bit sent_last = 0;
    while (idx < n) begin
      @(negedge clk_i);
      if ($urandom_range(99, 0) < gap_pct) begin
        word_valid_i = 1'b0;
        word_i = 40'($urandom);
        continue;
      end
      for (int i = 0; i < 5; i++)
        word_i[39-8*i -: 8] = (idx + i < n) ? frm[idx+i] : 8'hA5;  // R4 junk below count
      word_last_i  = (idx + 5 >= n);
      word_bytes_i = word_last_i ? 4'(n - idx) : 4'd5;
      word_valid_i = 1'b1;
      #(CLK_PERIOD/4);
      if (word_ready_o) begin
        sent_last = word_last_i;
        idx += 5;
      end
    end
    @(negedge clk_i);
    word_valid_i = 1'b0;
    word_last_i  = 1'b0;
    #(CLK_PERIOD/4);
    if (sent_last) check("R8 input closed after last word", word_ready_o, 0);
  endtask

  task automatic run_frame();
    expect_frame();
    send_frame();
    while (exp_bytes.size() != 0) @(negedge clk_i);
    frm.delete();
  endtask

  // output readiness
  initial forever begin
    @(negedge clk_i);
    case (rdy_mode)
      0: desc_ready_i = 1'b1;
      1: desc_ready_i = 1'($urandom);
      default: desc_ready_i = ($urandom_range(3, 0) == 0);
    endcase
  end

  // per-cycle comparison against the model
  bit          prev_stall = 0;
  logic [39:0] prev_bytes = '0;
  initial forever begin
    @(negedge clk_i);
    #(CLK_PERIOD/4);
    if (rst_ni) begin
      if (prev_stall) begin
        check("R6 valid held under stall", desc_valid_o, 1);
        check("R6 bytes held under stall", desc_bytes_o, prev_bytes);
      end
      prev_stall = desc_valid_o && !desc_ready_i;
      prev_bytes = desc_bytes_o;
      if (desc_valid_o && desc_ready_i) begin
        if (exp_bytes.size() == 0) begin
          check("R5 R9 unexpected descriptor", 1, 0);
        end else begin
          check("R1 kind", desc_kind_o, exp_kind[0]);
          check("R2 R4 R5 bytes", desc_bytes_o, exp_bytes[0]);
          check("R3 run length", desc_run_o, exp_run[0]);
          check("R7 last flag", desc_last_o, exp_last[0]);
          void'(exp_bytes.pop_front());
          void'(exp_kind.pop_front());
          void'(exp_run.pop_front());
          void'(exp_last.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL R5 watchdog expired, pending=%0d expected=0", exp_bytes.size());
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 desc_valid in reset", desc_valid_o, 0);
    check("R10 word_ready in reset", word_ready_o, 1);
    rst_ni = 1'b1;

    // all kinds, several straddling words, run bounds 1 and 62
    rdy_mode = 0; gap_pct = 0;
    frm = '{8'hFE, 8'h10, 8'h20, 8'h30, 8'h00, 8'h7F, 8'h80, 8'h3A,
            8'hFF, 8'h01, 8'h02, 8'h03, 8'h04, 8'hC0, 8'hFD, 8'h3F, 8'h9A, 8'h55};
    run_frame();

    // single-byte frame
    frm = '{8'hC5};
    run_frame();

    rdy_mode = 1; gap_pct = 20;
    for (int i = 0; i < 60; i++) add_rand();
    run_frame();

    // R9 truncated tail: RGBA tag with only two payload bytes
    frm = '{8'h41, 8'h82, 8'h11, 8'hFF, 8'h11, 8'h22};
    run_frame();
    repeat (4) @(negedge clk_i);
    #(CLK_PERIOD/4);
    check("R9 input reopened after dropped tail", word_ready_o, 1);

    rdy_mode = 2; gap_pct = 30;
    for (int i = 0; i < 100; i++) add_rand();
    run_frame();

    rdy_mode = 0; gap_pct = 0;
    for (int i = 0; i < 40; i++) add_rand();
    run_frame();

    repeat (5) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule